// File: doc/BRIEF.md
# Power Management Wake Event Controller

This block holds the wake configuration and event status of a network controller and drives an active-low power-management wake request toward the system. Two sources can raise a wake event: a one-cycle detect pulse from an external frame pattern detector, and a change of the PHY link status after the link watch has been armed. Both sources count only while the device sits in a low-power state (D1, D2 or D3).

The link watch samples the synchronized link status when software writes its enable as one, and keeps that value as the reference. Any later difference from the reference, in either direction, records a link event. Two things cancel the watch: a return to D0 from a low-power state, and a write that clears the link enable. Status bits are sticky and write-one-to-clear. The wake output stays low for as long as an enabled, latched event exists and output assertion is on.

Software sees the block through one 8-bit register with a write strobe and a combinational read value. Power-state sequencing and the host bus protocol belong to the surrounding logic.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After reset, rd_data_o reads 0x00 and wake_no is 1.
- R2: Register layout: bit0 out_en, bit1 pat_en and bit2 link_en are written directly and read back as written. Bit4 pat_evt and bit5 link_evt are status bits. Bits 3, 6 and 7 always read 0.
- R3: link_ok_i passes through two flops before comparison. A change applied just after an edge cannot set link_evt before the third following edge, and does set it at that edge.
- R4: Every write with bit2 = 1 arms the link watch and captures the synchronized link status as the reference. While armed and in D1–D3, a synchronized link status that differs from the reference sets link_evt. Both directions count (1 to 0 and 0 to 1). Recording an event disarms the watch.
- R5: The watch is disarmed by entering D0 (pwr_state_i becomes 00 after a non-00 value) or by any write with bit2 = 0. A link change after either of these sets no link_evt.
- R6: A pattern_hit_i pulse sets pat_evt at the next edge only when pat_en = 1 and the power state is not D0.
- R7: Power-state encoding is 00 = D0, 01 = D1, 10 = D2 and 11 = D3. No status bit is set while the state is 00.
- R8: Status bits are write-one-to-clear. Writing 1 to bit4 or bit5 clears that bit. Writing 0 leaves it unchanged. A set and a clear in the same cycle leave the bit set.
- R9: wake_no is 0 exactly when out_en = 1 and at least one status bit is set whose own enable is 1 (pat_en for bit4, link_en for bit5). Status bits are recorded even when out_en is 0.
- R10: Entering D0 does not clear latched status bits, and the wake output keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| pwr_state_i | input | 2 | Current power state (00 = D0 … 11 = D3) |
| link_ok_i | input | 1 | Asynchronous PHY link status, 1 = link up |
| pattern_hit_i | input | 1 | One-cycle pulse from the frame pattern detector |
| wake_no | output | 1 | Wake request, active low |

## Verification
The pattern source is swept over all four power states, both pattern-enable values and both output-enable values. This separates a gating error on the state from one on the enable or on the output. The link source is swept over both reference levels and every low-power state, so a watch that fires in only one direction or in only some states is exposed. Separate sequences check that the event lands on exactly the third edge, that D0 entry and an enable clear each cancel a pending watch, and that write-one-to-clear, set-over-clear, output disable and D0 entry each leave the status and wake levels as R8–R10 specify.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
  localparam int unsigned PWR_W    = 2;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_EVT  = 2;
  localparam int unsigned SYNC_LEN = 2;

  localparam logic [PWR_W-1:0] PWR_D0 = '0;

  // register bit positions
  localparam int unsigned BIT_OUT_EN   = 0;
  localparam int unsigned BIT_PAT_EN   = 1;
  localparam int unsigned BIT_LINK_EN  = 2;
  localparam int unsigned BIT_EVT_BASE = 4;

  // event indices
  localparam int unsigned EVT_PAT  = 0;
  localparam int unsigned EVT_LINK = 1;

  typedef struct packed {
    logic link_en;
    logic pat_en;
    logic out_en;
  } wake_cfg_t;
endpackage

// File: rtl/pm_wake_sync.sv
module pm_wake_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pm_wake_link_watch.sv
module pm_wake_link_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_s_i,
  input  logic arm_i,
  input  logic disarm_i,
  input  logic low_pwr_i,
  output logic hit_o,
  output logic armed_o
);
  logic armed_q, ref_q;

  assign hit_o   = armed_q & low_pwr_i & (link_s_i ^ ref_q);
  assign armed_o = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ref_q   <= 1'b0;
    end else if (disarm_i) begin
      armed_q <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      ref_q   <= link_s_i;
    end else if (hit_o) begin
      armed_q <= 1'b0;
    end
  end

  p_disarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i |=> !armed_q);
  p_arm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !disarm_i) |=> (armed_q && ref_q == $past(link_s_i)));
  p_one_shot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !arm_i) |=> !armed_q);
endmodule

// File: rtl/pm_wake_status.sv
module pm_wake_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] evt_q;

  for (genvar i = 0; i < N; i++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       evt_q[i] <= 1'b0;
      else if (set_i[i]) evt_q[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) evt_q[i] <= 1'b0;
    end

    p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !evt_q[i]);
    p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_q[i] && !clr_i[i]) |=> evt_q[i]);
    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> evt_q[i]);
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_wake_pkg::*;
#(
  parameter int unsigned P_W    = PWR_W,
  parameter int unsigned R_W    = REG_W,
  parameter int unsigned N_SYNC = SYNC_LEN
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [R_W-1:0] wr_data_i,
  output logic [R_W-1:0] rd_data_o,
  input  logic [P_W-1:0] pwr_state_i,
  input  logic           link_ok_i,
  input  logic           pattern_hit_i,
  output logic           wake_no
);
  localparam logic [P_W-1:0] D0 = P_W'(PWR_D0);

  wake_cfg_t        cfg_q;
  logic [P_W-1:0]   pwr_prev_q;
  logic             low_pwr, d0_entry, arm, disarm;
  logic             link_s, link_hit, link_armed;
  logic [NUM_EVT-1:0] evt_set, evt_clr, evt, evt_en;

  assign low_pwr  = pwr_state_i != D0;
  assign d0_entry = !low_pwr && (pwr_prev_q != D0);
  assign arm      = wr_en_i &&  wr_data_i[BIT_LINK_EN];
  assign disarm   = d0_entry || (wr_en_i && !wr_data_i[BIT_LINK_EN]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      pwr_prev_q <= D0;
    end else begin
      pwr_prev_q <= pwr_state_i;
      if (wr_en_i) begin
        cfg_q.out_en  <= wr_data_i[BIT_OUT_EN];
        cfg_q.pat_en  <= wr_data_i[BIT_PAT_EN];
        cfg_q.link_en <= wr_data_i[BIT_LINK_EN];
      end
    end
  end

  pm_wake_sync #(.STAGES(N_SYNC), .RST_VAL(1'b0)) i_link_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (link_ok_i),
    .q_o   (link_s)
  );

  pm_wake_link_watch i_link_watch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .link_s_i (link_s),
    .arm_i    (arm),
    .disarm_i (disarm),
    .low_pwr_i(low_pwr),
    .hit_o    (link_hit),
    .armed_o  (link_armed)
  );

  always_comb begin
    evt_set           = '0;
    evt_set[EVT_PAT]  = pattern_hit_i && cfg_q.pat_en && low_pwr;
    evt_set[EVT_LINK] = link_hit;
    evt_en            = '0;
    evt_en[EVT_PAT]   = cfg_q.pat_en;
    evt_en[EVT_LINK]  = cfg_q.link_en;
    for (int i = 0; i < NUM_EVT; i++)
      evt_clr[i] = wr_en_i && wr_data_i[BIT_EVT_BASE+i];
  end

  pm_wake_status #(.N(NUM_EVT)) i_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_set),
    .clr_i (evt_clr),
    .evt_o (evt)
  );

  always_comb begin
    rd_data_o              = '0;
    rd_data_o[BIT_OUT_EN]  = cfg_q.out_en;
    rd_data_o[BIT_PAT_EN]  = cfg_q.pat_en;
    rd_data_o[BIT_LINK_EN] = cfg_q.link_en;
    for (int i = 0; i < NUM_EVT; i++)
      rd_data_o[BIT_EVT_BASE+i] = evt[i];
  end

  assign wake_no = !(cfg_q.out_en && |(evt & evt_en));

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
    p_evt_only_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt[i]) |-> $past(low_pwr));
  end

  p_pattern_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt[EVT_PAT]) |-> $past(pattern_hit_i && cfg_q.pat_en));
  p_link_needs_arm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt[EVT_LINK]) |-> $past(link_armed));
  p_wake_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_no && !wr_en_i) |=> !wake_no);
  p_d0_keeps_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d0_entry && !wr_en_i) |=> $stable(evt));
endmodule

// File: tb/test_pm_wake_ctrl.sv
module test_pm_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] pwr = 2'b00;
  logic       link_ok = 1'b0;
  logic       hit = 1'b0;
  logic       wake_no;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pm_wake_ctrl i_pm_wake_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .rd_data_o    (rd_data),
    .pwr_state_i  (pwr),
    .link_ok_i    (link_ok),
    .pattern_hit_i(hit),
    .wake_no      (wake_no)
  );

  task automatic chk(input int got, input int exp, input string tag);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse();
    @(negedge clk);
    hit = 1'b1;
    @(negedge clk);
    hit = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(2);
    chk(rd_data, 8'h00, "R1 reset read");
    chk(wake_no, 1, "R1 reset wake");
    rst_ni = 1'b1;
    tick(1);

    // R2: layout
    wr(8'hFF);
    chk(rd_data, 8'h07, "R2 write all ones");
    wr(8'h02);
    chk(rd_data, 8'h02, "R2 pat_en only");
    wr(8'h00);
    chk(rd_data, 8'h00, "R2 all clear");

    // R6/R7/R9: pattern sweep
    for (int st = 0; st < 4; st++)
      for (int pe = 0; pe < 2; pe++)
        for (int oe = 0; oe < 2; oe++) begin
          logic [7:0] cfg;
          int exp;
          cfg = 8'(oe | (pe << 1));
          pwr = 2'(st);
          wr(cfg);
          pulse();
          exp = (pe == 1 && st != 0) ? 1 : 0;
          chk(rd_data[4], exp, $sformatf("R6 R7 pat_evt st=%0d pe=%0d oe=%0d", st, pe, oe));
          chk(wake_no, (oe == 1 && exp == 1) ? 0 : 1, $sformatf("R9 wake st=%0d pe=%0d oe=%0d", st, pe, oe));
          wr(cfg | 8'h10);
          chk(rd_data, cfg, "R8 w1c pattern");
          chk(wake_no, 1, "R8 wake after clear");
        end

    // R3/R4: link sweep, both directions
    for (int init = 0; init < 2; init++)
      for (int st = 1; st < 4; st++) begin
        pwr = 2'b00;
        link_ok = init[0];
        tick(4);
        wr(8'h05);
        pwr = 2'(st);
        tick(4);
        chk(rd_data[5], 0, $sformatf("R4 no change no event init=%0d st=%0d", init, st));
        link_ok = ~init[0];
        tick(2);
        chk(rd_data[5], 0, $sformatf("R3 too early init=%0d st=%0d", init, st));
        tick(1);
        chk(rd_data[5], 1, $sformatf("R3 R4 link_evt init=%0d st=%0d", init, st));
        chk(wake_no, 0, $sformatf("R9 link wake init=%0d st=%0d", init, st));
        wr(8'h21);
        chk(rd_data, 8'h01, "R8 w1c link");
        chk(wake_no, 1, "R9 link wake released");
      end

    // R5: disarm by enable clear
    pwr = 2'b11; link_ok = 1'b1;
    tick(4);
    wr(8'h05);
    wr(8'h01);
    link_ok = 1'b0;
    tick(5);
    chk(rd_data, 8'h01, "R5 enable clear disarms");

    // R5: disarm by D0 entry
    pwr = 2'b10;
    tick(4);
    wr(8'h05);
    @(negedge clk) pwr = 2'b00;
    @(negedge clk) pwr = 2'b10;
    link_ok = 1'b1;
    tick(5);
    chk(rd_data, 8'h05, "R5 D0 entry disarms");
    wr(8'h00);

    // R10: D0 keeps status
    pwr = 2'b01;
    wr(8'h03);
    pulse();
    pwr = 2'b00;
    tick(4);
    chk(rd_data, 8'h13, "R10 status kept in D0");
    chk(wake_no, 0, "R10 wake kept in D0");

    // R9: output or source disable
    wr(8'h02);
    chk(wake_no, 1, "R9 out_en off releases");
    chk(rd_data, 8'h12, "R9 status still latched");
    wr(8'h01);
    chk(wake_no, 1, "R9 pat_en off masks");
    wr(8'h03);
    chk(wake_no, 0, "R9 re-enable asserts");
    wr(8'h13);

    // R8: set beats clear, zero write leaves bit
    pwr = 2'b01;
    @(negedge clk);
    hit = 1'b1; wr_en = 1'b1; wr_data = 8'h13;
    @(negedge clk);
    hit = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk(rd_data[4], 1, "R8 set wins over clear");
    wr(8'h03);
    chk(rd_data[4], 1, "R8 zero write keeps bit");
    wr(8'h13);
    chk(rd_data[4], 0, "R8 one write clears");

    finish_run();
  end
endmodule